// File: doc/BRIEF.md
# Multi-Slave SPI Master with Per-Slave Mode and Rate

This block is an SPI master that serves several slaves on one shared clock, one shared data-out line and one shared data-in line. Each slave has its own active-low select line. Each slave also has its own stored settings: clock polarity, clock phase and a clock divider. The settings are written through a small configuration port and survive across transfers.

A transfer starts with a one-cycle request that names a slave and carries a data word. The master takes that slave's settings and moves the serial clock to the slave's idle level while every select is still high. It then asserts only that slave's select and waits one half-period. It shifts the word out most significant bit first while it samples the incoming bit stream on the edges the slave's mode calls for. After the last edge it keeps the select low for one more half-period and then releases it. In the cycle the select returns high, it pulses a done strobe with the received word.

The block is meant for a system controller that talks to a mix of peripherals with different clock modes and speeds. It does not need to reprogram a global mode between accesses.

Top module: `spi_multi_master`

## Requirements
- R1: At most one select line is low at any time. During a transfer only the requested slave's line is low, and all lines are high while the master is idle.
- R2: A configuration write stores clock polarity, clock phase and divider for the addressed slave only. After reset every slave has polarity 0, phase 0 and divider DEF_DIV.
- R3: The serial clock reaches the target slave's polarity level before that slave's select falls. The serial clock never changes in a cycle in which any select line changes.
- R4: The mode is encoded as polarity and phase bits. Mode 0 (0,0) and mode 3 (1,1) sample on rising edges and shift on falling edges. Mode 1 (0,1) and mode 2 (1,0) sample on falling edges and shift on rising edges. Each transfer makes exactly 2×DATA_W clock edges.
- R5: Transfers are full duplex and most significant bit first. The slave receives the request word, and the word the slave returns appears on rxData.
- R6: One half-period of the serial clock lasts divider+1 system cycles. The select falls exactly one half-period before the first clock edge, and consecutive edges are one half-period apart.
- R7: The select stays low for exactly one half-period after the last edge. done is high for exactly one cycle: the first cycle in which all selects are high again, and rxData is valid in that cycle.
- R8: A request that arrives while busy is high is ignored. A configuration write during a transfer does not change that transfer's timing or mode, but applies to later transfers. A request that names a slave number at or above the slave count is ignored.
- R9: During and right after reset all selects are high, the serial clock is low, and done and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for one slave's settings |
| cfgSlave | input | SEL_W | Slave whose settings are written |
| cfgCpol | input | 1 | Clock idle level to store |
| cfgCpha | input | 1 | Clock phase to store |
| cfgDiv | input | DIV_W | Divider to store; half-period is divider+1 cycles |
| reqStart | input | 1 | One-cycle transfer request |
| reqSlave | input | SEL_W | Target slave of the request |
| reqData | input | DATA_W | Word to send |
| miso | input | 1 | Serial data from the slaves |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slaves |
| csN | output | NUM_SLAVES | Active-low select, one bit per slave |
| rxData | output | DATA_W | Word received in the last transfer |
| busy | output | 1 | High from an accepted request until done |
| done | output | 1 | One-cycle end-of-transfer strobe |

## Verification
The embedded properties assume that every input is synchronous to clk. They also assume that miso changes only on the shift edges of the active mode, so it is steady through each sample edge. The bench drives all requests and configuration writes half a cycle away from the rising clock edge. Its slave model updates miso only after a shift edge has been observed, so this assumption always holds. Requests during a transfer are made on purpose, so the ignore rule is exercised rather than assumed away.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_SETUP,
    ST_RUN,
    ST_HOLD,
    ST_FIN
  } mm_state_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;      // take new word and move sclk to idle level
    logic toggle;    // make one clock edge
    logic shiftOut;  // present next outgoing bit
    logic sampleIn;  // capture miso
    logic capture;   // publish received word
  } dp_strobe_t;

endpackage

// File: rtl/spi_mm_cfg.sv
module spi_mm_cfg #(
  parameter int NUM_SLAVES = 4,
  parameter int DIV_W      = 8,
  parameter int DEF_DIV    = 1,
  parameter int SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrIdx,
  input  logic             wrCpol,
  input  logic             wrCpha,
  input  logic [DIV_W-1:0] wrDiv,
  input  logic [SEL_W-1:0] rdIdx,
  output logic             rdCpol,
  output logic             rdCpha,
  output logic [DIV_W-1:0] rdDiv
);

  logic             cpolQ [NUM_SLAVES];
  logic             cphaQ [NUM_SLAVES];
  logic [DIV_W-1:0] divQ  [NUM_SLAVES];

  for (genvar g = 0; g < NUM_SLAVES; g++) begin : gSlot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cpolQ[g] <= 1'b0;
        cphaQ[g] <= 1'b0;
        divQ[g]  <= DIV_W'(DEF_DIV);
      end else if (wrEn && (wrIdx == SEL_W'(g))) begin
        cpolQ[g] <= wrCpol;
        cphaQ[g] <= wrCpha;
        divQ[g]  <= wrDiv;
      end
    end
  end

  always_comb begin
    rdCpol = 1'b0;
    rdCpha = 1'b0;
    rdDiv  = DIV_W'(DEF_DIV);
    for (int i = 0; i < NUM_SLAVES; i++) begin
      if (rdIdx == SEL_W'(i)) begin
        rdCpol = cpolQ[i];
        rdCpha = cphaQ[i];
        rdDiv  = divQ[i];
      end
    end
  end

endmodule

// File: rtl/spi_mm_ctrl.sv
module spi_mm_ctrl
  import spi_mm_pkg::*;
#(
  parameter int NUM_SLAVES = 4,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int SEL_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [SEL_W-1:0]      startIdx,
  input  logic                  rdCpha,
  input  logic [DIV_W-1:0]      rdDiv,
  output dp_strobe_t            dp,
  output logic [NUM_SLAVES-1:0] csN,
  output logic                  busy,
  output logic                  done
);

  localparam int EC_W = $clog2(2 * DATA_W + 1);
  localparam logic [EC_W-1:0] FINAL_EDGE = EC_W'(2 * DATA_W);

  mm_state_e        state;
  logic [SEL_W-1:0] selIdx;
  logic             cphaR;
  logic [DIV_W-1:0] divR;
  logic [DIV_W-1:0] cnt;
  logic [EC_W-1:0]  edgeCnt;

  logic            startOk;
  logic            edgeNow;
  logic [EC_W-1:0] edgeIdx;
  logic            isSample;

  assign startOk  = start && ({1'b0, startIdx} < (SEL_W + 1)'(NUM_SLAVES));
  assign edgeNow  = ((state == ST_SETUP) || (state == ST_RUN)) && (cnt == '0);
  assign edgeIdx  = (state == ST_SETUP) ? EC_W'(1) : edgeCnt + EC_W'(1);
  // odd edges lead; phase 0 samples on leading, phase 1 on trailing
  assign isSample = edgeIdx[0] ^ cphaR;

  always_comb begin
    dp          = '0;
    dp.load     = (state == ST_IDLE) && startOk;
    dp.toggle   = edgeNow;
    dp.sampleIn = edgeNow && isSample;
    dp.shiftOut = edgeNow && !isSample && (edgeIdx != EC_W'(1));
    dp.capture  = (state == ST_HOLD) && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      selIdx  <= '0;
      cphaR   <= 1'b0;
      divR    <= '0;
      cnt     <= '0;
      edgeCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startOk) begin
          selIdx <= startIdx;
          cphaR  <= rdCpha;
          divR   <= rdDiv;
          state  <= ST_PREP;
        end
        ST_PREP: begin
          cnt   <= divR;
          state <= ST_SETUP;
        end
        ST_SETUP, ST_RUN: begin
          if (edgeNow) begin
            edgeCnt <= edgeIdx;
            cnt     <= divR;
            state   <= (edgeIdx == FINAL_EDGE) ? ST_HOLD : ST_RUN;
          end else begin
            cnt <= cnt - DIV_W'(1);
          end
        end
        ST_HOLD: begin
          if (cnt == '0) state <= ST_FIN;
          else cnt <= cnt - DIV_W'(1);
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    csN = '1;
    if ((state == ST_SETUP) || (state == ST_RUN) || (state == ST_HOLD))
      csN = ~(NUM_SLAVES'(1) << selIdx);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~csN) <= 1); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((&csN) && !(&$past(csN)))); // R7
  AST_BUSY_KEEPS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(selIdx)); // R8

endmodule

// File: rtl/spi_mm_datapath.sv
module spi_mm_datapath
  import spi_mm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_strobe_t        dp,
  input  logic              loadCpol,
  input  logic [DATA_W-1:0] txWord,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk    <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
    end else begin
      if (dp.load) begin
        sclk    <= loadCpol;
        txShift <= txWord;
      end
      if (dp.toggle)   sclk    <= ~sclk;
      if (dp.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (dp.sampleIn) rxShift <= {rxShift[DATA_W-2:0], miso};
      if (dp.capture)  rxData  <= rxShift;
    end
  end

  assign mosi = txShift[DATA_W-1];

  AST_MOSI_STEADY_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    dp.sampleIn |=> $stable(mosi)); // R4

endmodule

// File: rtl/spi_multi_master.sv
module spi_multi_master
  import spi_mm_pkg::*;
#(
  parameter int NUM_SLAVES = 4,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int DEF_DIV    = 1,
  localparam int SEL_W     = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfgWrEn,
  input  logic [SEL_W-1:0]      cfgSlave,
  input  logic                  cfgCpol,
  input  logic                  cfgCpha,
  input  logic [DIV_W-1:0]      cfgDiv,
  input  logic                  reqStart,
  input  logic [SEL_W-1:0]      reqSlave,
  input  logic [DATA_W-1:0]     reqData,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic [NUM_SLAVES-1:0] csN,
  output logic [DATA_W-1:0]     rxData,
  output logic                  busy,
  output logic                  done
);

  dp_strobe_t       dpStrobe;
  logic             rdCpol;
  logic             rdCpha;
  logic [DIV_W-1:0] rdDiv;

  spi_mm_cfg #(
    .NUM_SLAVES(NUM_SLAVES), .DIV_W(DIV_W), .DEF_DIV(DEF_DIV), .SEL_W(SEL_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wrEn(cfgWrEn), .wrIdx(cfgSlave), .wrCpol(cfgCpol), .wrCpha(cfgCpha), .wrDiv(cfgDiv),
    .rdIdx(reqSlave), .rdCpol(rdCpol), .rdCpha(rdCpha), .rdDiv(rdDiv)
  );

  spi_mm_ctrl #(
    .NUM_SLAVES(NUM_SLAVES), .DATA_W(DATA_W), .DIV_W(DIV_W), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start(reqStart), .startIdx(reqSlave), .rdCpha(rdCpha), .rdDiv(rdDiv),
    .dp(dpStrobe), .csN(csN), .busy(busy), .done(done)
  );

  spi_mm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .dp(dpStrobe), .loadCpol(rdCpol), .txWord(reqData), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rxData(rxData)
  );

  AST_SCLK_STILL_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(csN) |-> $stable(sclk)); // R3

endmodule

// File: tb/spi_multi_master_tb.sv
`timescale 1ns/1ps
module spi_multi_master_tb;

  localparam int NS = 4;
  localparam int DW = 8;
  localparam int VW = 8;
  localparam int DEFD = 1;

  typedef struct packed {
    logic [1:0] slv;
    logic       cpol;
    logic       cpha;
    logic [7:0] div;
    logic [7:0] tx;
    logic [7:0] rx;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 8'd0, 8'hA5, 8'h3C},
    '{2'd1, 1'b0, 1'b1, 8'd1, 8'h81, 8'h7E},
    '{2'd2, 1'b1, 1'b0, 8'd2, 8'h00, 8'hFF},
    '{2'd3, 1'b1, 1'b1, 8'd3, 8'hFF, 8'h00},
    '{2'd0, 1'b1, 1'b1, 8'd0, 8'h5A, 8'hC3},
    '{2'd2, 1'b0, 1'b1, 8'd4, 8'h01, 8'h80},
    '{2'd1, 1'b1, 1'b0, 8'd0, 8'h80, 8'h01}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [1:0]    cfgSlave = '0;
  logic          cfgCpol = 1'b0;
  logic          cfgCpha = 1'b0;
  logic [VW-1:0] cfgDiv = '0;
  logic          reqStart = 1'b0;
  logic [1:0]    reqSlave = '0;
  logic [DW-1:0] reqData = '0;
  logic          miso = 1'b0;
  logic          sclk, mosi, busy, done;
  logic [NS-1:0] csN;
  logic [DW-1:0] rxData;

  int total = 0;
  int bad = 0;

  spi_multi_master #(.NUM_SLAVES(NS), .DATA_W(DW), .DIV_W(VW), .DEF_DIV(DEFD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgSlave(cfgSlave), .cfgCpol(cfgCpol),
    .cfgCpha(cfgCpha), .cfgDiv(cfgDiv), .reqStart(reqStart), .reqSlave(reqSlave),
    .reqData(reqData), .miso(miso), .sclk(sclk), .mosi(mosi), .csN(csN),
    .rxData(rxData), .busy(busy), .done(done)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model and line monitor, all at the falling clock edge
  logic          curCpol = 1'b0;
  logic          curCpha = 1'b0;
  logic [1:0]    curSel = '0;
  logic [DW-1:0] curSlvWord = '0;
  int            curH = 1;
  logic          prevActive = 1'b0;
  logic          prevSclk = 1'b0;
  int            selCyc = 0;
  int            lastEdge = 0;
  int            mEdges = 0;
  int            mSetup = 0;
  int            mHold = 0;
  bit            mGapBad = 1'b0;
  bit            mSelBad = 1'b0;
  logic          mSclkAtSel = 1'b0;
  logic [DW-1:0] slvShift = '0;
  logic [DW-1:0] slvRx = '0;

  always @(negedge clk) begin
    logic active;
    logic leading;
    active = (csN != '1);
    if (active) begin
      if (!prevActive) begin
        selCyc = 0; mEdges = 0; mGapBad = 1'b0; mSelBad = 1'b0;
        mSclkAtSel = sclk; slvShift = curSlvWord; miso = curSlvWord[DW-1]; slvRx = '0;
      end else begin
        selCyc++;
        if (sclk != prevSclk) begin
          mEdges++;
          if (mEdges == 1) mSetup = selCyc;
          else if (selCyc - lastEdge != curH) mGapBad = 1'b1;
          lastEdge = selCyc;
          leading = (sclk != curCpol);
          if (leading ^ curCpha) slvRx = {slvRx[DW-2:0], mosi};
          else if (mEdges != 1) begin
            slvShift = {slvShift[DW-2:0], 1'b0};
            miso = slvShift[DW-1];
          end
        end
      end
      if (csN != ~(NS'(1) << curSel)) mSelBad = 1'b1;
    end else if (prevActive) begin
      mHold = selCyc + 1 - lastEdge;
    end
    prevActive = active;
    prevSclk = sclk;
  end

  task automatic writeCfg(input logic [1:0] s, input logic p, input logic h, input logic [VW-1:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSlave = s; cfgCpol = p; cfgCpha = h; cfgDiv = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // poke: request another transfer and rewrite this slave's settings mid-transfer
  task automatic runXfer(input logic [1:0] s, input logic p, input logic h, input int d,
                         input logic [DW-1:0] tx, input logic [DW-1:0] sw, input bit poke);
    int waited;
    curCpol = p; curCpha = h; curSel = s; curSlvWord = sw; curH = d + 1;
    @(negedge clk);
    reqStart = 1'b1; reqSlave = s; reqData = tx;
    @(negedge clk);
    reqStart = 1'b0;
    waited = 0;
    while (!done) begin
      waited++;
      if (poke && waited == 6) begin
        chk("R8 busy during transfer", busy == 1'b1, int'(busy), 1);
        reqStart = 1'b1; reqSlave = s + 2'd3; reqData = 8'h77;
        cfgWrEn = 1'b1; cfgSlave = s; cfgCpol = 1'b1; cfgCpha = 1'b1; cfgDiv = '0;
      end else begin
        reqStart = 1'b0; cfgWrEn = 1'b0;
      end
      @(negedge clk);
    end
    reqStart = 1'b0; cfgWrEn = 1'b0;
    chk("R7 selects high at done", csN == '1, int'(csN), 15);
    chk("R5 received word", rxData == sw, int'(rxData), int'(sw));
    @(negedge clk);
    chk("R7 done one cycle", done == 1'b0, int'(done), 0);
    chk("R8 busy low after done", busy == 1'b0, int'(busy), 0);
    chk("R4 edge count", mEdges == 2 * DW, mEdges, 2 * DW);
    chk("R4 R5 slave got word msb first", slvRx == tx, int'(slvRx), int'(tx));
    chk("R3 clock idle level at select", mSclkAtSel == p, int'(mSclkAtSel), int'(p));
    chk("R6 setup delay", mSetup == d + 1, mSetup, d + 1);
    chk("R6 half period spacing", mGapBad == 1'b0, int'(mGapBad), 0);
    chk("R7 hold delay", mHold == d + 1, mHold, d + 1);
    chk("R1 only target selected", mSelBad == 1'b0, int'(mSelBad), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 selects in reset", csN == '1, int'(csN), 15);
    chk("R9 sclk in reset", sclk == 1'b0, int'(sclk), 0);
    chk("R9 done in reset", done == 1'b0, int'(done), 0);
    chk("R9 busy in reset", busy == 1'b0, int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 selects after reset", csN == '1, int'(csN), 15);
    chk("R9 busy after reset", busy == 1'b0, int'(busy), 0);

    // R2 defaults: slave 1 unconfigured, mode 0, divider DEFD
    runXfer(2'd1, 1'b0, 1'b0, DEFD, 8'hC6, 8'h93, 1'b0);

    // main table, all four modes and several rates
    for (int i = 0; i < NV; i++) begin
      writeCfg(VECS[i].slv, VECS[i].cpol, VECS[i].cpha, VECS[i].div);
      runXfer(VECS[i].slv, VECS[i].cpol, VECS[i].cpha, int'(VECS[i].div),
              VECS[i].tx, VECS[i].rx, 1'b0);
    end

    // R2 writes to one slave leave others alone: slave 3 still mode 3 div 3
    runXfer(2'd3, 1'b1, 1'b1, 3, 8'h3E, 8'hD4, 1'b0);

    // R8 request and config write during a transfer
    writeCfg(2'd0, 1'b0, 1'b1, 8'd2);
    runXfer(2'd0, 1'b0, 1'b1, 2, 8'h96, 8'h69, 1'b1);
    for (int k = 0; k < 10; k++) begin
      chk("R8 ignored request starts nothing", csN == '1 && busy == 1'b0, int'(csN), 15);
      @(negedge clk);
    end
    // R8 the mid-transfer write applies now: mode 3, divider 0
    runXfer(2'd0, 1'b1, 1'b1, 0, 8'h2B, 8'hE1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule